// File: doc/BRIEF.md
# Cascadable Serial-In Latched Output Driver

This block is the digital core of a multi-channel display driver. A serial bit stream is clocked into a chain of stages by rising edges of an external shift clock. A bank of latches sits between the stages and the parallel outputs. While the strobe is high the latches follow the stages. While the strobe is low they hold, so a new frame can be shifted in without disturbing the display. A blanking input forces every output low and leaves the latch contents alone. The last stage drives a serial output, so several devices can share one shift clock and strobe and be chained into one long register for a wide display.

All asynchronous inputs (serial data, shift clock, strobe, blanking) are brought into a single system clock through two-flop synchronizers. Shift-clock rising edges are detected in that clock domain. Data and shift clock pass through synchronizers of the same depth, so the data bit present at the shift-clock edge is the one captured. A synchronous active-high reset clears all storage.

Top module: `drv_serial_latch`

## Requirements
- R1: While `rst` is high at a system clock edge, all stages, all latches, `par_out` and `ser_out` become 0 at that edge.
- R2: Each rising edge of `shift_clk` (synchronized) performs one shift: stage 1 takes `ser_in` and stage k takes the old stage k-1. When there is no rising edge, including while `shift_clk` is held high and `ser_in` changes, the stages do not change.
- R3: `ser_out` carries the contents of the last stage (stage NUM_CH). Two devices chained from `ser_out` to `ser_in` behave as one register of 2*NUM_CH stages.
- R4: While `strobe` is high, each latch follows its stage. This includes shifts that happen while the strobe stays high.
- R5: While `strobe` is low, the latches hold their values and `par_out` does not change when new data is shifted in.
- R6: While `blank` is high, `par_out` is all zeros. When `blank` returns low, `par_out` shows the latch contents again, and those contents are unchanged.
- R7: `par_out[k]` is driven from the latch of stage k+1. After NUM_CH shifts, the first bit shifted in appears on `par_out[NUM_CH-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data in (asynchronous) |
| shift_clk | input | 1 | Shift clock; its rising edge shifts (asynchronous) |
| strobe | input | 1 | Latch enable: high means transparent, low means hold (asynchronous) |
| blank | input | 1 | High forces all outputs low (asynchronous) |
| par_out | output | NUM_CH | Registered parallel outputs; bit k is stage k+1 |
| ser_out | output | 1 | Last stage, for cascading |

## Verification
The checker tests the following on every system clock cycle: stages stay stable without a detected edge, a shift moves the contents by one position, the serial output tracks the stage below it, the latches follow while the strobe is high and hold while it is low, blanking forces the outputs to zero, and the outputs mirror the latches. Only the bench scenarios can show the end-to-end channel order, meaning which input bit lands on which output after 2*NUM_CH shifts through two chained devices. They also show that a shift clock held high produces exactly one shift, and that the latch contents survive a blanking period.

// File: rtl/drv_pkg.sv
package drv_pkg;
  localparam int DEF_NUM_CH      = 10;
  localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/drv_sync.sv
module drv_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/drv_shift.sv
module drv_shift #(
  parameter int NUM_CH = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              din_s,
  output logic              rise,
  output logic [NUM_CH-1:0] stages
);
  logic sclk_d;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign rise = sclk_s & ~sclk_d;

  generate
    if (NUM_CH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)       stages <= '0;
        else if (rise) stages <= din_s;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)       stages <= '0;
        else if (rise) stages <= {stages[NUM_CH-2:0], din_s};
      end
    end
  endgenerate
endmodule

// File: rtl/drv_latch.sv
module drv_latch #(
  parameter int NUM_CH = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_s,
  input  logic              blank_s,
  input  logic [NUM_CH-1:0] stages,
  output logic [NUM_CH-1:0] held,
  output logic [NUM_CH-1:0] par_out
);
  genvar k;
  generate
    for (k = 0; k < NUM_CH; k++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst) begin
          held[k]    <= 1'b0;
          par_out[k] <= 1'b0;
        end else begin
          if (strobe_s) held[k] <= stages[k];
          par_out[k] <= blank_s ? 1'b0 : held[k];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/drv_serial_latch.sv
module drv_serial_latch
  import drv_pkg::*;
#(
  parameter int NUM_CH      = DEF_NUM_CH,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              shift_clk,
  input  logic              strobe,
  input  logic              blank,
  output logic [NUM_CH-1:0] par_out,
  output logic              ser_out
);
  localparam int NUM_IN = 4;

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] syn_in;
  logic              shift_rise;
  logic [NUM_CH-1:0] stages;
  logic [NUM_CH-1:0] held;

  assign raw_in = {blank, strobe, shift_clk, ser_in};

  drv_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn_in)
  );

  drv_shift #(.NUM_CH(NUM_CH)) u_shift (
    .clk(clk), .rst(rst), .sclk_s(syn_in[1]), .din_s(syn_in[0]),
    .rise(shift_rise), .stages(stages)
  );

  drv_latch #(.NUM_CH(NUM_CH)) u_latch (
    .clk(clk), .rst(rst), .strobe_s(syn_in[2]), .blank_s(syn_in[3]),
    .stages(stages), .held(held), .par_out(par_out)
  );

  assign ser_out = stages[NUM_CH-1];
endmodule

// File: rtl/drv_serial_latch_chk.sv
module drv_serial_latch_chk #(
  parameter int NUM_CH = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              rise,
  input logic              strobe_s,
  input logic              blank_s,
  input logic [NUM_CH-1:0] stages,
  input logic [NUM_CH-1:0] held,
  input logic [NUM_CH-1:0] par_out,
  input logic              ser_out
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (stages == '0 && held == '0 && par_out == '0 && ser_out == 1'b0));

  assert_noshift_R2: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(stages));

  generate
    if (NUM_CH > 1) begin : g_multi
      assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
        rise |=> stages[NUM_CH-1:1] == $past(stages[NUM_CH-2:0]));
      assert_serout_R3: assert property (@(posedge clk) disable iff (rst)
        rise |=> ser_out == $past(stages[NUM_CH-2]));
    end
  endgenerate

  assert_follow_R4: assert property (@(posedge clk) disable iff (rst)
    strobe_s |=> held == $past(stages));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !strobe_s |=> $stable(held));

  assert_blank_R6: assert property (@(posedge clk) disable iff (rst)
    blank_s |=> par_out == '0);

  assert_map_R7: assert property (@(posedge clk) disable iff (rst)
    !blank_s |=> par_out == $past(held));
endmodule

bind drv_serial_latch drv_serial_latch_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .rise(shift_rise), .strobe_s(syn_in[2]),
  .blank_s(syn_in[3]), .stages(stages), .held(held),
  .par_out(par_out), .ser_out(ser_out)
);

// File: tb/tb_drv_serial_latch.sv
module tb_drv_serial_latch;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst, ser_in, shift_clk, strobe, blank;
  logic [N-1:0] par_a, par_b;
  logic ser_a, ser_b;

  int checks = 0;
  int fails  = 0;
  logic [2*N-1:0] chain;
  logic [2*N-1:0] shown;

  localparam logic [2*N-1:0] VEC [4] = '{
    20'hA5C3F, 20'h00001, 20'h80000, 20'h5A5A5
  };

  always #4 clk = ~clk;

  drv_serial_latch #(.NUM_CH(N)) dut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .shift_clk(shift_clk),
    .strobe(strobe), .blank(blank), .par_out(par_a), .ser_out(ser_a)
  );

  drv_serial_latch #(.NUM_CH(N)) dut_b (
    .clk(clk), .rst(rst), .ser_in(ser_a), .shift_clk(shift_clk),
    .strobe(strobe), .blank(blank), .par_out(par_b), .ser_out(ser_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b;
    idle(4);
    shift_clk = 1'b1;
    idle(6);
    shift_clk = 1'b0;
    idle(6);
    chain = {chain[2*N-2:0], b};
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1;
    idle(8);
    strobe = 1'b0;
    idle(8);
    shown = chain;
  endtask

  task automatic chk_outputs(input string tag, input logic [2*N-1:0] exp);
    chk(tag, {22'b0, par_a}, {22'b0, exp[N-1:0]});
    chk(tag, {22'b0, par_b}, {22'b0, exp[2*N-1:N]});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(4);
    rst = 1'b0;
    idle(2);
    chain = '0;
    shown = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    ser_in = 0; shift_clk = 0; strobe = 0; blank = 0;
    do_reset();

    // R1: reset state
    chk("R1 par", {22'b0, par_a}, 32'h0);
    chk("R1 ser", {31'b0, ser_b}, 32'h0);

    // R7: single one travels to the top channel after N shifts
    shift_bit(1'b1);
    for (int i = 1; i < N; i++) shift_bit(1'b0);
    pulse_strobe();
    chk("R7 top channel", {22'b0, par_a}, 32'h200);
    chk("R7 second device empty", {22'b0, par_b}, 32'h0);

    // R3/R4/R5 vector table: shift closed, check hold, open, check
    for (int v = 0; v < 4; v++) begin
      for (int i = 0; i < 2*N; i++) shift_bit(VEC[v][i]);
      chk_outputs("R5 hold while closed", shown);
      pulse_strobe();
      chk_outputs("R3 chained pattern", chain);
      chk("R3 ser_out", {31'b0, ser_b}, {31'b0, chain[2*N-1]});
    end

    // R4: transparent while strobe stays high
    strobe = 1'b1;
    idle(8);
    shift_bit(1'b1);
    idle(4);
    chk_outputs("R4 follows shift", chain);
    shift_bit(1'b0);
    idle(4);
    chk_outputs("R4 follows second shift", chain);
    strobe = 1'b0;
    idle(8);
    shown = chain;

    // R6: blanking zeros outputs, latches kept
    blank = 1'b1;
    idle(8);
    chk_outputs("R6 blanked", '0);
    blank = 1'b0;
    idle(8);
    chk_outputs("R6 restored", shown);

    // R2: shift clock held high gives one shift only
    ser_in = 1'b1;
    idle(4);
    shift_clk = 1'b1;
    idle(6);
    chain = {chain[2*N-2:0], 1'b1};
    for (int i = 0; i < 6; i++) begin
      ser_in = ~ser_in;
      idle(5);
    end
    shift_clk = 1'b0;
    idle(6);
    pulse_strobe();
    chk_outputs("R2 single shift on held clock", chain);

    // R1: reset mid-run clears everything
    do_reset();
    idle(4);
    chk_outputs("R1 cleared after run", '0);
    chk("R1 ser after run", {31'b0, ser_a}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule